// File: doc/BRIEF.md
# I2C Register-File Target with Clock Stretching

This block is an I2C target that gives a bus controller access to a small bank of byte-wide registers. It samples the open-drain SCL and SDA lines through synchronizers, recognises START, repeated START and STOP, compares the 7-bit address, and acknowledges every byte it accepts. It drives the lines only by pulling them low, through two separate enables.

A write transfer carries a register index in its first data byte and register contents in every later byte. A read transfer returns the registers from the current index onward. The index is kept between transfers and wraps past the last register. After the ACK of a read address the target always holds SCL low for a programmed number of system clocks, even if write stretching is turned off. During that time it loads the first outgoing byte. Later read bytes are prepared during the controller's acknowledge clock, so the target never stretches between them. On the local side, a parallel port reads and writes the same registers.

Top module: `i2c_regmap_target`

## Requirements
- R1: After reset both drive enables are low, every register reads 0 and the register index is 0, so the first bus read returns 0x00.
- R2: A byte after START whose upper 7 bits equal DEV_ADDR is acknowledged (SDA pulled low on the ninth clock); bit 0 of that byte selects read (1) or write (0). Any other address gets no acknowledge, and the data that follows changes no register.
- R3: In a write transfer the first data byte sets the register index (value modulo NREGS) and is not stored in any register.
- R4: Every further write data byte is stored at the register index, and the index then advances by one.
- R5: A matched read loads the register at the index into the transmit shifter and advances the index. Each byte acknowledged by the controller is followed by the next register, so consecutive reads return consecutive registers.
- R6: The index wraps from NREGS-1 to 0, on writes and on reads.
- R7: After a matched read address, SCL is held low for exactly hold_len+1 system clocks during the acknowledge, whatever wr_stretch_en is.
- R8: SCL is never held low between or during the data bytes of a read.
- R9: With wr_stretch_en high, SCL is held low once after every received write data byte. With it low, SCL is never held low in a write transfer.
- R10: When the controller does not acknowledge a read byte, the target releases SDA and ignores further clocks until the next START. A STOP releases both lines. A repeated START begins a new address phase.
- R11: A local write (loc_we high for one clock) stores loc_wdata at loc_addr. loc_rdata always shows the register at loc_addr. A bus write in the same clock takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| wr_stretch_en | input | 1 | Enable SCL hold after received write bytes |
| hold_len | input | HW | Hold length minus one, in system clocks |
| loc_addr | input | AW | Local register index |
| loc_we | input | 1 | Local write strobe |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Register at loc_addr |

## Verification
The hardest behaviour to reach is the forced hold after a read address. It lasts only a few system clocks and falls inside the controller's own low phase, so it never shows in the data. The bench models the bus with wired-AND logic and measures the length of every SCL-low pulse from the target. It then compares the pulse counts and lengths per transfer phase against hold_len and wr_stretch_en, for several settings. Pointer wrap is reached by starting writes and reads at the last register, and by sending an index byte larger than the register count.

// File: rtl/i2c_regmap_target.sv
module i2c_regmap_target #(
  parameter logic [6:0] DEV_ADDR = 7'h42,
  parameter int NREGS = 8,
  parameter int HW = 4,
  localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          wr_stretch_en,
  input  logic [HW-1:0] hold_len,
  input  logic [AW-1:0] loc_addr,
  input  logic          loc_we,
  input  logic [7:0]    loc_wdata,
  output logic [7:0]    loc_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_WACK, S_TX, S_RACK} st_t;

  st_t           st;
  logic [2:0]    scl_q, sda_q;
  logic [7:0]    sh, tx;
  logic [3:0]    bitcnt;
  logic          rd, first, mack;
  logic [AW-1:0] ptr;
  logic [HW-1:0] hcnt;
  logic [7:0]    regs [NREGS];

  wire scl_s = scl_q[1];
  wire scl_p = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_p = sda_q[2];
  wire rise  = scl_s & ~scl_p;
  wire fall  = ~scl_s & scl_p;
  wire start = scl_s & scl_p & sda_p & ~sda_s;
  wire stop  = scl_s & scl_p & ~sda_p & sda_s;

  assign loc_rdata = regs[loc_addr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(NREGS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= '1;
      sda_q  <= '1;
      st     <= S_IDLE;
      sh     <= '0;
      tx     <= '0;
      bitcnt <= '0;
      rd     <= 1'b0;
      first  <= 1'b0;
      mack   <= 1'b0;
      ptr    <= '0;
      hcnt   <= '0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (loc_we) regs[loc_addr] <= loc_wdata;
      if (scl_oe) begin
        if (hcnt == '0) scl_oe <= 1'b0;
        else hcnt <= hcnt - 1'b1;
      end
      if (stop) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else if (start) begin
        st     <= S_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_RX: begin
            if (rise) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (fall && bitcnt == 4'd8) begin
              if (st == S_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  st     <= S_AACK;
                  sda_oe <= 1'b1;
                  rd     <= sh[0];
                  first  <= 1'b1;
                  if (sh[0]) begin
                    tx     <= regs[ptr];
                    ptr    <= nxt(ptr);
                    scl_oe <= 1'b1;
                    hcnt   <= hold_len;
                  end
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                st     <= S_WACK;
                sda_oe <= 1'b1;
                first  <= 1'b0;
                if (first) begin
                  ptr <= AW'(sh % NREGS);
                end else begin
                  regs[ptr] <= sh;
                  ptr       <= nxt(ptr);
                end
                if (wr_stretch_en) begin
                  scl_oe <= 1'b1;
                  hcnt   <= hold_len;
                end
              end
            end
          end
          S_AACK, S_WACK: begin
            if (fall) begin
              bitcnt <= '0;
              if (st == S_AACK && rd) begin
                st     <= S_TX;
                sda_oe <= ~tx[7];
              end else begin
                st     <= S_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (fall) begin
              if (bitcnt == 4'd7) begin
                st     <= S_RACK;
                sda_oe <= 1'b0;
              end else begin
                bitcnt <= bitcnt + 1'b1;
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          S_RACK: begin
            if (rise) begin
              mack <= ~sda_s;
            end else if (fall) begin
              if (mack) begin
                tx     <= regs[ptr];
                ptr    <= nxt(ptr);
                st     <= S_TX;
                bitcnt <= '0;
                sda_oe <= ~regs[ptr][7];
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic [HW:0] hrun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hrun <= '0;
    else hrun <= scl_oe ? hrun + 1'b1 : '0;
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(ptr) < NREGS); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_ADDR && st == S_AACK && rd) |-> scl_oe); // R7
  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hrun) <= (1 << HW)); // R7
  AST_TX_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX || st == S_RACK) |-> !scl_oe); // R8
  AST_WR_HOLD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WACK && scl_oe) |-> wr_stretch_en); // R9
  AST_RACK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK) |-> !sda_oe); // R10
  AST_STOP_REL: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!sda_oe && !scl_oe)); // R10

endmodule

// File: tb/sim_i2c_regmap_target.sv
module sim_i2c_regmap_target;
  localparam int NREGS = 8;
  localparam logic [6:0] DEV = 7'h42;
  localparam int Q = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic       scl_oe, sda_oe, scl_bus, sda_bus;
  logic       wr_en = 1'b0;
  logic [3:0] hold = '0;
  logic [2:0] loc_addr = '0;
  logic       loc_we = 1'b0;
  logic [7:0] loc_wdata = '0, loc_rdata;

  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_regmap_target #(.DEV_ADDR(DEV), .NREGS(NREGS), .HW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .wr_stretch_en(wr_en), .hold_len(hold),
    .loc_addr(loc_addr), .loc_we(loc_we), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata));

  int errors = 0, checks = 0, runs = 0, run = 0, last_run = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (scl_oe) run <= run + 1;
    else if (run != 0) begin
      last_run <= run;
      runs     <= runs + 1;
      run      <= 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl = 1'b1;
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wq(Q); scl_up(); wq(Q);
    m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(Q); scl_up(); wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q); scl_up(); wq(Q); m_scl = 1'b0;
    end
    m_sda = 1'b1; wq(Q); scl_up(); wq(Q/2);
    ack = ~sda_bus; wq(Q/2); m_scl = 1'b0;
  endtask

  task automatic rbyte(input logic ack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_up(); wq(Q/2); d[i] = sda_bus; wq(Q/2); m_scl = 1'b0;
    end
    m_sda = ~ack; wq(Q); scl_up(); wq(Q); m_scl = 1'b0; wq(4); m_sda = 1'b1;
  endtask

  task automatic wr_seq(input logic [7:0] p, input logic [7:0] d0, input logic [7:0] d1,
                        input int n, output logic aok);
    logic a;
    i2c_start();
    wbyte({DEV, 1'b0}, aok);
    wbyte(p, a);
    if (n > 0) wbyte(d0, a);
    if (n > 1) wbyte(d1, a);
    i2c_stop();
  endtask

  function automatic logic [7:0] peek_idx(input int i);
    return 8'(i % NREGS);
  endfunction

  task automatic peek(input int i, output logic [7:0] v);
    loc_addr = 3'(peek_idx(i)); wq(1); v = loc_rdata;
  endtask

  localparam logic [31:0] VEC [4] = '{
    32'h02A53C00, 32'h07112215, 32'h0DC37E1F, 32'h04FF0009 };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] r0, r1, v;
    int r;
    wq(5); rst_n = 1'b1; wq(5);

    // R1 reset state
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    peek(0, v); chk("R1 reg0", v, 0);
    i2c_start(); wbyte({DEV, 1'b1}, a); rbyte(1'b0, r0); i2c_stop();
    chk("R1 first read", r0, 8'h00);

    // R2 foreign address: no ack, no effect
    i2c_start(); wbyte({7'h13, 1'b0}, a);
    chk("R2 foreign nack", a, 0);
    wbyte(8'h01, a); wbyte(8'h77, a); i2c_stop();
    peek(1, v); chk("R2 foreign no write", v, 0);

    // vector table: write two bytes, set pointer, read back
    foreach (VEC[k]) begin
      logic [7:0] p, d0, d1;
      p = VEC[k][31:24]; d0 = VEC[k][23:16]; d1 = VEC[k][15:8];
      wr_en = VEC[k][4]; hold = VEC[k][3:0];
      r = runs;
      wr_seq(p, d0, d1, 2, a);
      chk("R2 address ack", a, 1);
      chk("R9 write holds", runs - r, wr_en ? 3 : 0);
      peek(int'(p), v); chk("R4 first stored", v, d0);
      peek(int'(p) + 1, v); chk("R6 second stored", v, d1);
      wr_seq(p, 8'h00, 8'h00, 0, a);
      r = runs;
      i2c_start(); wbyte({DEV, 1'b1}, a);
      chk("R7 one read hold", runs - r, 1);
      chk("R7 hold length", last_run, int'(hold) + 1);
      r = runs;
      rbyte(1'b1, r0); rbyte(1'b0, r1); i2c_stop();
      chk("R5 read first", r0, d0);
      chk("R5 read next", r1, d1);
      chk("R8 no data hold", runs - r, 0);
    end

    // R3 index byte not stored
    wr_en = 1'b0;
    wr_seq(8'h06, 8'h00, 8'h00, 0, a);
    wr_seq(8'h03, 8'h66, 8'h00, 1, a);
    peek(6, v); chk("R3 index not stored", v, 8'h7E);
    peek(3, v); chk("R3 data at index", v, 8'h66);

    // R10 repeated start
    i2c_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h03, a);
    m_sda = 1'b1; wq(Q); i2c_start();
    wbyte({DEV, 1'b1}, a); rbyte(1'b0, r0); i2c_stop();
    chk("R10 repeated start read", r0, 8'h66);

    // R10 nack releases line
    i2c_start(); wbyte({DEV, 1'b1}, a); rbyte(1'b0, r0);
    rbyte(1'b0, r1);
    chk("R10 released after nack", r1, 8'hFF);
    chk("R10 sda_oe low", sda_oe, 0);
    i2c_stop();

    // R11 local write then bus read
    loc_addr = 3'd2; loc_wdata = 8'h5A; loc_we = 1'b1; wq(1); loc_we = 1'b0;
    wq(1); chk("R11 local readback", loc_rdata, 8'h5A);
    wr_seq(8'h02, 8'h00, 8'h00, 0, a);
    i2c_start(); wbyte({DEV, 1'b1}, a); rbyte(1'b0, r0); i2c_stop();
    chk("R11 bus sees local write", r0, 8'h5A);

    // R6 read wrap from last register
    wr_seq(8'h07, 8'h00, 8'h00, 0, a);
    i2c_start(); wbyte({DEV, 1'b1}, a); rbyte(1'b1, r0); rbyte(1'b0, r1); i2c_stop();
    chk("R6 read at last", r0, 8'h11);
    chk("R6 read wraps", r1, 8'h22);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule